// File: doc/BRIEF.md
# Receive Descriptor Ring Deposit Engine

This block takes received frames one at a time from a byte stream and places each one into host memory through a ring of receive descriptors that software owns. The whole frame is first gathered into an internal buffer, so its size is known before any memory traffic starts. The engine then walks the ring from where the previous search stopped. It skips any descriptor that is not marked available or whose length is too small. The frame goes into the first descriptor that qualifies. That descriptor is then rewritten as filled, and a one-cycle receive event is raised.

If no descriptor qualifies within one full lap of the ring, or if the frame is larger than the internal buffer, the frame is discarded and a one-cycle drop pulse is raised instead. Software places the ring with two configuration registers: a base address, and an entry count held minus one. Memory is reached through a simple request/acknowledge port that can read or write one 32-bit word.

Top module: `rxring_deposit`

## Requirements
- R1: After reset the stream input is ready, no memory request is pending, and neither the event nor the drop output is high. The ring index is zero, the base address is zero and the ring holds one entry.
- R2: Descriptor i is located at base + 8*i. The word at +0 holds the buffer address. The word at +4 holds the length in bits 15:0 and the flags in bits 31:16. A write to offset 0x104 sets the base. A write to offset 0x108 sets the entry count to bits 31:16 plus one.
- R3: A descriptor is taken only if flag bit 15 (word bit 31) is set and its length is at least the frame size. Any other descriptor is left unchanged in memory and passed over.
- R4: Byte j of the frame is written to buffer address + j, with one byte per request. The strobe is 1 << address[1:0] and the byte is replicated on all four lanes. No byte past the frame end is written.
- R5: After the data, the word at descriptor + 4 is rewritten as {16'h0011, frame size}. The buffer address word is not written.
- R6: A successful deposit produces exactly one rx_event pulse. It comes in the cycle after the descriptor write is acknowledged, and no drop pulse is produced.
- R7: Each search starts at the saved index. Before each examination, an index at or beyond the entry count is replaced by zero. The index advances past every descriptor examined, including the one that is used.
- R8: When no descriptor qualifies within entry-count examinations, the frame is discarded. Exactly one rx_drop pulse is produced, nothing is written, and no event is raised.
- R9: A frame longer than BUF_BYTES bytes is accepted to its end and then discarded with one rx_drop pulse. It causes no memory request at all.
- R10: in_ready is low from the cycle after the last byte is accepted until the frame is deposited or dropped. It is never high while a memory request is pending. A pending request holds its address and direction until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration register offset |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_ready | output | 1 | Engine accepts a byte |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 32 | Write data |
| mem_wstrb | output | 4 | Byte lane enables for writes |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data |
| rx_drop | output | 1 | One-cycle pulse: frame discarded |
| rx_event | output | 1 | One-cycle pulse: frame deposited |

## Verification
The bench builds the engine with BUF_BYTES = 16. This makes the oversize path reachable with frames of 17 and 40 bytes, and lets frame sizes of 1, 6 and 16 meet descriptor lengths that are smaller, equal and larger. For each ring size from one to four entries, every pattern of available flags is swept. Because the saved index carries over between cases and ring sizes, wrap-around and the full-lap drop are reached many times. Memory answers with a latency that rotates through 0, 1 and 2 wait cycles, and buffers start at every byte offset within a word.

// File: rtl/rx_dep_pkg.sv
package rx_dep_pkg;
  localparam int          DESC_BYTES   = 8;
  localparam int          AVAIL_BIT    = 31;
  localparam logic [15:0] FILLED_FLAGS = 16'h0011;
  localparam int          RW           = 17;

  typedef enum logic [2:0] {
    ST_COLLECT,
    ST_CHECK,
    ST_RD_LF,
    ST_RD_BUF,
    ST_WR_BYTE,
    ST_WR_DESC
  } walk_st_t;
endpackage

// File: rtl/rx_ring_cfg.sv
module rx_ring_cfg
  import rx_dep_pkg::*;
#(
  parameter int              CFG_AW   = 12,
  parameter logic [CFG_AW-1:0] BASE_OFS = 'h104,
  parameter logic [CFG_AW-1:0] SIZE_OFS = 'h108
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       ring_base,
  output logic [RW-1:0]     ring_cnt
);
  logic [31:0] base_q, base_d;
  logic [15:0] szf_q, szf_d;
  logic        base_en, size_en;
  logic        unused_lo;

  assign unused_lo = ^cfg_wdata[15:0];
  assign base_en   = cfg_we && (cfg_addr == BASE_OFS);
  assign size_en   = cfg_we && (cfg_addr == SIZE_OFS);

  always_comb begin
    base_d = base_q;
    szf_d  = szf_q;
    if (base_en) base_d = cfg_wdata;
    if (size_en) szf_d  = cfg_wdata[31:16];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      szf_q  <= '0;
    end else begin
      base_q <= base_d;
      szf_q  <= szf_d;
    end
  end

  assign ring_base = base_q;
  assign ring_cnt  = {1'b0, szf_q} + RW'(1);

  // R2
  ring_field_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    size_en |=> (ring_cnt == {1'b0, $past(cfg_wdata[31:16])} + RW'(1)));
endmodule

// File: rtl/rx_frame_store.sv
module rx_frame_store #(
  parameter int BUF_BYTES = 1628,
  localparam int LEN_W = $clog2(BUF_BYTES + 1),
  localparam int PTR_W = $clog2(BUF_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  input  logic             in_ready,
  input  logic [PTR_W-1:0] rd_addr,
  output logic [7:0]       rd_byte,
  output logic             frame_done,
  output logic [LEN_W-1:0] frame_len,
  output logic             frame_big
);
  localparam logic [LEN_W-1:0] CAP = LEN_W'(BUF_BYTES);

  logic [7:0]       store_q [BUF_BYTES];
  logic [LEN_W-1:0] cnt_q, cnt_d, len_q, len_d;
  logic             done_q, done_d, big_q, big_d;
  logic             acc, wen;

  assign acc = in_valid & in_ready;

  always_comb begin
    cnt_d  = cnt_q;
    len_d  = len_q;
    big_d  = big_q;
    done_d = 1'b0;
    wen    = 1'b0;
    if (acc) begin
      wen = (cnt_q < CAP);
      if (in_last) begin
        done_d = 1'b1;
        big_d  = (cnt_q == CAP);
        len_d  = (cnt_q == CAP) ? cnt_q : cnt_q + LEN_W'(1);
        cnt_d  = '0;
      end else if (cnt_q != CAP) begin
        cnt_d = cnt_q + LEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      len_q  <= '0;
      big_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      len_q  <= len_d;
      big_q  <= big_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wen) store_q[cnt_q[PTR_W-1:0]] <= in_data;
  end

  assign rd_byte    = store_q[rd_addr];
  assign frame_done = done_q;
  assign frame_len  = len_q;
  assign frame_big  = big_q;

  // R9
  frame_len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (big_q || (len_q != '0 && len_q <= CAP)));
endmodule

// File: rtl/rx_desc_walker.sv
module rx_desc_walker
  import rx_dep_pkg::*;
#(
  parameter int BUF_BYTES = 1628,
  localparam int LEN_W = $clog2(BUF_BYTES + 1),
  localparam int PTR_W = $clog2(BUF_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_done,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             frame_big,
  input  logic [31:0]      ring_base,
  input  logic [RW-1:0]    ring_cnt,
  output logic [PTR_W-1:0] rd_addr,
  input  logic [7:0]       rd_byte,
  output logic             busy,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  output logic [3:0]       mem_wstrb,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic             rx_event,
  output logic             rx_drop
);
  walk_st_t         st_q, st_d;
  logic [RW-1:0]    idx_q, idx_d, seen_q, seen_d, cur_idx;
  logic [31:0]      da_q, da_d, bp_q, bp_d;
  logic [LEN_W-1:0] len_q, len_d, bi_q, bi_d;
  logic             ev_q, ev_d, dr_q, dr_d;
  logic             fits;

  assign cur_idx = (idx_q >= ring_cnt) ? '0 : idx_q;
  assign fits    = mem_rdata[AVAIL_BIT] && (mem_rdata[15:0] >= 16'(len_q));

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    seen_d = seen_q;
    da_d   = da_q;
    bp_d   = bp_q;
    len_d  = len_q;
    bi_d   = bi_q;
    ev_d   = 1'b0;
    dr_d   = 1'b0;
    case (st_q)
      ST_COLLECT: begin
        if (frame_done) begin
          if (frame_big) begin
            dr_d = 1'b1;
          end else begin
            len_d  = frame_len;
            seen_d = '0;
            st_d   = ST_CHECK;
          end
        end
      end
      ST_CHECK: begin
        if (seen_q >= ring_cnt) begin
          dr_d = 1'b1;
          st_d = ST_COLLECT;
        end else begin
          idx_d = cur_idx;
          da_d  = ring_base + 32'({cur_idx, 3'b000});
          st_d  = ST_RD_LF;
        end
      end
      ST_RD_LF: begin
        if (mem_ack) begin
          idx_d  = idx_q + RW'(1);
          seen_d = seen_q + RW'(1);
          st_d   = fits ? ST_RD_BUF : ST_CHECK;
        end
      end
      ST_RD_BUF: begin
        if (mem_ack) begin
          bp_d = mem_rdata;
          bi_d = '0;
          st_d = ST_WR_BYTE;
        end
      end
      ST_WR_BYTE: begin
        if (mem_ack) begin
          if (bi_q == len_q - LEN_W'(1)) st_d = ST_WR_DESC;
          else bi_d = bi_q + LEN_W'(1);
        end
      end
      ST_WR_DESC: begin
        if (mem_ack) begin
          ev_d = 1'b1;
          st_d = ST_COLLECT;
        end
      end
      default: st_d = ST_COLLECT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_COLLECT;
      idx_q  <= '0;
      seen_q <= '0;
      da_q   <= '0;
      bp_q   <= '0;
      len_q  <= '0;
      bi_q   <= '0;
      ev_q   <= 1'b0;
      dr_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      seen_q <= seen_d;
      da_q   <= da_d;
      bp_q   <= bp_d;
      len_q  <= len_d;
      bi_q   <= bi_d;
      ev_q   <= ev_d;
      dr_q   <= dr_d;
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = da_q + 32'd4;
    mem_wdata = '0;
    mem_wstrb = 4'hF;
    case (st_q)
      ST_RD_LF:  mem_req = 1'b1;
      ST_RD_BUF: begin
        mem_req  = 1'b1;
        mem_addr = da_q;
      end
      ST_WR_BYTE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = bp_q + 32'(bi_q);
        mem_wdata = {4{rd_byte}};
        mem_wstrb = 4'b0001 << mem_addr[1:0];
      end
      ST_WR_DESC: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = {FILLED_FLAGS, 16'(len_q)};
      end
      default: ;
    endcase
  end

  assign rd_addr  = bi_q[PTR_W-1:0];
  assign busy     = (st_q != ST_COLLECT);
  assign rx_event = ev_q;
  assign rx_drop  = dr_q;

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R6
  event_after_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WR_DESC && mem_ack) |=> (rx_event && !rx_drop));
  // R8
  single_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_event && rx_drop));
  // R4
  byte_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WR_BYTE) |-> (bi_q < len_q && $onehot(mem_wstrb)));
endmodule

// File: rtl/rxring_deposit.sv
module rxring_deposit
  import rx_dep_pkg::*;
#(
  parameter int                BUF_BYTES = 1628,
  parameter int                CFG_AW    = 12,
  parameter logic [CFG_AW-1:0] BASE_OFS  = 'h104,
  parameter logic [CFG_AW-1:0] SIZE_OFS  = 'h108,
  localparam int LEN_W = $clog2(BUF_BYTES + 1),
  localparam int PTR_W = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_wstrb,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              rx_drop,
  output logic              rx_event
);
  logic [31:0]      ring_base;
  logic [RW-1:0]    ring_cnt;
  logic [PTR_W-1:0] rd_addr;
  logic [7:0]       rd_byte;
  logic             frame_done, frame_big, busy;
  logic [LEN_W-1:0] frame_len;

  assign in_ready = ~busy & ~frame_done;

  rx_ring_cfg #(
    .CFG_AW(CFG_AW), .BASE_OFS(BASE_OFS), .SIZE_OFS(SIZE_OFS)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ring_base(ring_base), .ring_cnt(ring_cnt)
  );

  rx_frame_store #(.BUF_BYTES(BUF_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .rd_addr(rd_addr),
    .rd_byte(rd_byte), .frame_done(frame_done), .frame_len(frame_len),
    .frame_big(frame_big)
  );

  rx_desc_walker #(.BUF_BYTES(BUF_BYTES)) u_walk (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_len(frame_len),
    .frame_big(frame_big), .ring_base(ring_base), .ring_cnt(ring_cnt),
    .rd_addr(rd_addr), .rd_byte(rd_byte), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .rx_event(rx_event), .rx_drop(rx_drop)
  );

  // R10
  no_ready_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !in_ready);
  // R9
  big_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && frame_big) |=> (!mem_req && rx_drop));
endmodule

// File: tb/test_rxring_deposit.sv
module test_rxring_deposit;
  localparam int BUFB = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [11:0] cfg_addr;
  logic [31:0] cfg_wdata;
  logic        in_valid, in_last, in_ready;
  logic [7:0]  in_data;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_wstrb;
  logic        rx_drop, rx_event;

  logic [31:0] mem [256];
  int n_chk = 0, n_fail = 0;
  int ev_cnt = 0, dr_cnt = 0, nwr = 0, nrd = 0, viol = 0;
  int lat = 0, wcnt = 0, cyc = 0;
  int idx_model = 0;
  int ring_base = 'h100;
  logic        pend_q = 1'b0;
  logic [31:0] pend_addr;
  logic        done_flag = 1'b0;

  always #2.5 clk = ~clk;

  rxring_deposit #(.BUF_BYTES(BUFB)) i_rxring_deposit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wstrb(mem_wstrb), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rx_drop(rx_drop), .rx_event(rx_event)
  );

  // memory model with rotating latency 0..2
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      wcnt    <= 0;
    end else if (mem_req && !mem_ack) begin
      if (wcnt >= lat) begin
        mem_ack <= 1'b1;
        wcnt    <= 0;
        lat     <= (lat + 1) % 3;
        if (mem_we) begin
          for (int b = 0; b < 4; b++)
            if (mem_wstrb[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
          nwr <= nwr + 1;
        end else begin
          nrd <= nrd + 1;
        end
        mem_rdata <= mem[mem_addr[9:2]];
      end else begin
        wcnt <= wcnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (rx_event) ev_cnt <= ev_cnt + 1;
      if (rx_drop)  dr_cnt <= dr_cnt + 1;
      if (mem_req && in_ready) viol <= viol + 1;
      if (pend_q && (!mem_req || mem_addr != pend_addr)) viol <= viol + 1;
      pend_q    <= mem_req && !mem_ack;
      pend_addr <= mem_addr;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    wait (cyc > 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    finish_run();
  end

  function automatic logic [7:0] fb(input int s, input int j);
    return 8'h80 | 8'(j * 29 + s * 7);
  endfunction

  function automatic logic [7:0] getb(input int a);
    return mem[a[9:2]][8*a[1:0] +: 8];
  endfunction

  function automatic int buf_addr(input int k);
    return 'h200 + k * 'h20 + (k % 4);
  endfunction

  task automatic cfg_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send_frame(input int s);
    for (int j = 0; j < s; j++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = fb(s, j); in_last = (j == s - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    // R10: not ready right after the last byte
    chk(in_ready == 1'b0, "R10", in_ready, 0);
    while (!in_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_case(input int n, input int m, input int s);
    int lens[4] = '{3, 16, 1, 8};
    logic [31:0] w0[4], w1[4];
    int t, e_slot, ev0, dr0, wr0, bad, ba;
    for (int w = 128; w < 192; w++) mem[w] = '0;
    for (int k = 0; k < n; k++) begin
      w0[k] = buf_addr(k);
      w1[k] = {m[k] ? 16'h8000 : 16'h0000, 16'(lens[(k + n) % 4])};
      mem[(ring_base + 8 * k) / 4]     = w0[k];
      mem[(ring_base + 8 * k) / 4 + 1] = w1[k];
    end
    e_slot = -1;
    t = idx_model;
    for (int e = 0; e < n; e++) begin
      if (t >= n) t = 0;
      t++;
      if (w1[t-1][31] && int'(w1[t-1][15:0]) >= s) begin
        e_slot = t - 1;
        break;
      end
    end
    idx_model = t;
    ev0 = ev_cnt; dr0 = dr_cnt; wr0 = nwr;
    send_frame(s);
    if (e_slot >= 0) begin
      chk(ev_cnt == ev0 + 1 && dr_cnt == dr0, "R6", ev_cnt - ev0, 1);
      bad = 0;
      ba = buf_addr(e_slot);
      for (int j = 0; j < s; j++) if (getb(ba + j) != fb(s, j)) bad++;
      chk(bad == 0, "R4", bad, 0);
      chk(getb(ba + s) == 8'h00 && getb(ba - 1) == 8'h00, "R4", getb(ba + s), 0);
      chk(mem[(ring_base + 8 * e_slot) / 4 + 1] == {16'h0011, 16'(s)}, "R5",
          mem[(ring_base + 8 * e_slot) / 4 + 1], {16'h0011, 16'(s)});
      chk(mem[(ring_base + 8 * e_slot) / 4] == w0[e_slot], "R5",
          mem[(ring_base + 8 * e_slot) / 4], w0[e_slot]);
      chk(nwr - wr0 == s + 1, "R4", nwr - wr0, s + 1);
      for (int k = 0; k < n; k++)
        if (k != e_slot)
          chk(mem[(ring_base + 8 * k) / 4 + 1] == w1[k], "R7",
              mem[(ring_base + 8 * k) / 4 + 1], w1[k]);
    end else begin
      chk(dr_cnt == dr0 + 1 && ev_cnt == ev0, "R8", dr_cnt - dr0, 1);
      chk(nwr == wr0, "R8", nwr - wr0, 0);
      for (int k = 0; k < n; k++)
        chk(mem[(ring_base + 8 * k) / 4 + 1] == w1[k], "R3",
            mem[(ring_base + 8 * k) / 4 + 1], w1[k]);
    end
  endtask

  task automatic run_big(input int s);
    int ev0, dr0, wr0, rd0;
    ev0 = ev_cnt; dr0 = dr_cnt; wr0 = nwr; rd0 = nrd;
    send_frame(s);
    chk(dr_cnt == dr0 + 1 && ev_cnt == ev0, "R9", dr_cnt - dr0, 1);
    chk(nwr == wr0 && nrd == rd0, "R9", (nwr - wr0) + (nrd - rd0), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    in_valid = 1'b0; in_data = '0; in_last = 1'b0;
    for (int w = 0; w < 256; w++) mem[w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", in_ready, 1);
    chk(mem_req == 1'b0, "R1", mem_req, 0);
    chk(rx_event == 1'b0 && rx_drop == 1'b0, "R1", {rx_event, rx_drop}, 0);

    // R1/R2: default ring of one entry at base zero
    ring_base = 0;
    run_case(1, 1, 1);

    ring_base = 'h100;
    cfg_wr(12'h104, 32'(ring_base));
    for (int n = 1; n <= 4; n++) begin
      cfg_wr(12'h108, 32'(n - 1) << 16);
      for (int m = 0; m < (1 << n); m++) begin
        run_case(n, m, 1);
        run_case(n, m, 6);
        run_case(n, m, 16);
      end
    end

    run_big(17);
    run_big(40);
    run_case(4, 15, 16);

    // R2: relocated ring
    ring_base = 'h140;
    cfg_wr(12'h104, 32'(ring_base));
    cfg_wr(12'h108, 32'h0001_ABCD);
    run_case(2, 3, 5);
    run_case(2, 2, 3);

    chk(viol == 0, "R10", viol, 0);
    finish_run();
  end
endmodule